// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible register set of a four-channel DMA controller, reached over an 8-bit I/O bus with a 4-bit offset and separate write and read strobes. Each channel owns a 16-bit base/current address pair, a 16-bit base/current count pair and a six-bit mode. Shared controller state covers a mask bit per channel, a global disable bit and a latched terminal-count flag per channel.

Because the bus is one byte wide, each 16-bit register sits behind a single port. A shared byte pointer selects which half an access touches and flips after every access to a channel port. A set of write-only offsets act as commands: rewind the pointer, master reset, unmask all, write one mask bit, write every mask bit, or load a mode. The transfer engine sees the live mask, mode, current address and current count of every channel. It pulses a per-channel step input once per transferred unit. The block advances the current registers on that step and latches terminal count.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the disable bit is 0, every terminal-count flag is 0 and the byte pointer selects the low byte.
- R2: Offsets 0..7 are channel ports: channel = offset[2:1], offset[0]=0 is the address register and 1 the count register. Every write or read at these offsets flips the byte pointer, low byte first. A write of any value to offset 12 returns the pointer to the low byte.
- R3: A byte written to an address or count port updates the same byte of both the base and the current register. A read returns that byte of the current register.
- R4: A write to offset 13 (master reset) sets all masks, clears the disable bit and all terminal-count flags, and returns the pointer to low.
- R5: A write to offset 10 sets the mask of channel wdata[1:0] to wdata[2] (1 = masked).
- R6: A write to offset 15 loads mask n from wdata[n]. A write of any value to offset 14 clears all four masks.
- R7: A write to offset 11 stores wdata[7:2] as the mode of channel wdata[1:0], exported as ch_mode[6n+5:6n]. Within that field, bits 5:4 are the transfer mode, bit 3 selects decrement, bit 2 enables auto-initialise and bits 1:0 are the transfer type.
- R8: Reading offset 8 returns {req_in[3:0], tc[3:0]} and clears the terminal-count flags at the end of that cycle. A terminal count that occurs in the same cycle as the read stays latched.
- R9: Writing offset 8 loads the disable bit from wdata[2]. While the disable bit is set, or while a channel is masked, a step on that channel has no effect.
- R10: A step on an enabled channel moves the current address by one, up or down as the mode says, and decrements the current count. A step at count 0 latches terminal count. At that point, with auto-initialise set, the current registers reload from base. Without it, the count wraps to 0xFFFF and the channel's mask is set.
- R11: Reads at offsets 9..15 return 0. A write to offset 9 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| req_in | input | 4 | Pending request per channel, shown in status |
| step | input | 4 | One transferred unit per channel |
| ch_mask | output | 4 | Mask bit per channel |
| ch_mode | output | 24 | Six-bit mode per channel |
| ch_addr | output | 64 | Current address per channel, 16 bits each |
| ch_count | output | 64 | Current count per channel, 16 bits each |
| ctrl_disable | output | 1 | Controller disable bit |

## Verification
The contested cycle is a status read that coincides with a step that reaches terminal count. The bench raises the status read strobe and a step on a channel whose count is already zero in the same cycle. The read must return the flags from before the event. The next status read must show the new flag, and the read after that must show it cleared. The same event, on a channel without auto-initialise, must also set that channel's mask bit on the export.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
    localparam int NUM_CH   = 4;
    localparam int SEL_W    = $clog2(NUM_CH);
    localparam int BYTE_W   = 8;
    localparam int REG_W    = 2 * BYTE_W;
    localparam int MODE_W   = 6;
    localparam int OFS_W    = 4;
    localparam int DIS_BIT  = 2;
    localparam int SMASK_BIT = 2;

    localparam logic [OFS_W-1:0] OFS_CMD    = 4'd8;
    localparam logic [OFS_W-1:0] OFS_REQ    = 4'd9;
    localparam logic [OFS_W-1:0] OFS_SMASK  = 4'd10;
    localparam logic [OFS_W-1:0] OFS_MODE   = 4'd11;
    localparam logic [OFS_W-1:0] OFS_PTRCLR = 4'd12;
    localparam logic [OFS_W-1:0] OFS_MRST   = 4'd13;
    localparam logic [OFS_W-1:0] OFS_UNMASK = 4'd14;
    localparam logic [OFS_W-1:0] OFS_WMASK  = 4'd15;

    typedef struct packed {
        logic [1:0] xfer_mode;
        logic       addr_dec;
        logic       auto_init;
        logic [1:0] xfer_type;
    } chan_mode_t;

    typedef struct packed {
        logic [REG_W-1:0] base_addr;
        logic [REG_W-1:0] base_cnt;
        logic [REG_W-1:0] cur_addr;
        logic [REG_W-1:0] cur_cnt;
        chan_mode_t       mode;
    } chan_state_t;

    typedef struct packed {
        logic              dis;
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] tc;
    } ctrl_state_t;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic toggle,
    output logic hi_sel
);
    logic hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (clear)       hi_d = 1'b0;
        else if (toggle) hi_d = ~hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= hi_d;
    end

    assign hi_sel = hi_q;

    // R2
    ptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hi_sel);
    // R2
    ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && !clear) |=> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  chan_mode_t        mode_in,
    input  logic              step_en,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt,
    output chan_mode_t        mode,
    output logic              tc_evt
);
    chan_state_t      st_d, st_q;
    logic [REG_W-1:0] addr_next;

    always_comb begin
        st_d      = st_q;
        tc_evt    = 1'b0;
        addr_next = st_q.mode.addr_dec ? st_q.cur_addr - 1'b1 : st_q.cur_addr + 1'b1;

        if (step_en) begin
            if (st_q.cur_cnt == '0) begin
                tc_evt = 1'b1;
                if (st_q.mode.auto_init) begin
                    st_d.cur_addr = st_q.base_addr;
                    st_d.cur_cnt  = st_q.base_cnt;
                end else begin
                    st_d.cur_addr = addr_next;
                    st_d.cur_cnt  = '1;
                end
            end else begin
                st_d.cur_addr = addr_next;
                st_d.cur_cnt  = st_q.cur_cnt - 1'b1;
            end
        end

        if (addr_we) begin
            if (hi_sel) begin
                st_d.base_addr[REG_W-1:BYTE_W] = wdata;
                st_d.cur_addr[REG_W-1:BYTE_W]  = wdata;
            end else begin
                st_d.base_addr[BYTE_W-1:0] = wdata;
                st_d.cur_addr[BYTE_W-1:0]  = wdata;
            end
        end

        if (cnt_we) begin
            if (hi_sel) begin
                st_d.base_cnt[REG_W-1:BYTE_W] = wdata;
                st_d.cur_cnt[REG_W-1:BYTE_W]  = wdata;
            end else begin
                st_d.base_cnt[BYTE_W-1:0] = wdata;
                st_d.cur_cnt[BYTE_W-1:0]  = wdata;
            end
        end

        if (mode_we) st_d.mode = mode_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.cur_addr;
    assign cur_cnt  = st_q.cur_cnt;
    assign mode     = st_q.mode;

    // R10
    cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !cnt_we && (cur_cnt != '0)) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
    // R3
    addr_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !hi_sel) |=> (cur_addr[BYTE_W-1:0] == $past(wdata)));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              smask_we,
    input  logic              wmask_we,
    input  logic              unmask_cmd,
    input  logic              mrst_cmd,
    input  logic              stat_rd,
    input  logic [3:0]        wbits,
    input  logic [NUM_CH-1:0] tc_evt,
    input  logic [NUM_CH-1:0] auto_bits,
    output logic              dis,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] tc
);
    ctrl_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (cmd_we)     cs_d.dis = wbits[DIS_BIT];
        if (smask_we)   cs_d.mask[wbits[SEL_W-1:0]] = wbits[SMASK_BIT];
        if (wmask_we)   cs_d.mask = wbits[NUM_CH-1:0];
        if (unmask_cmd) cs_d.mask = '0;
        if (stat_rd)    cs_d.tc = '0;
        cs_d.tc   = cs_d.tc | tc_evt;
        cs_d.mask = cs_d.mask | (tc_evt & ~auto_bits);
        if (mrst_cmd) begin
            cs_d.dis  = 1'b0;
            cs_d.mask = '1;
            cs_d.tc   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.dis  <= 1'b0;
            cs_q.mask <= '1;
            cs_q.tc   <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign dis  = cs_q.dis;
    assign mask = cs_q.mask;
    assign tc   = cs_q.tc;

    // R4
    mrst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_cmd |=> (mask == '1 && tc == '0 && !dis));
    // R8
    tc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tc_evt) && !mrst_cmd) |=> ((tc & $past(tc_evt)) == $past(tc_evt)));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_regfile_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OFS_W-1:0]         io_addr,
    input  logic [BYTE_W-1:0]        io_wdata,
    input  logic                     io_wr,
    input  logic                     io_rd,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic [NUM_CH-1:0]        req_in,
    input  logic [NUM_CH-1:0]        step,
    output logic [NUM_CH-1:0]        ch_mask,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH*REG_W-1:0]  ch_addr,
    output logic [NUM_CH*REG_W-1:0]  ch_count,
    output logic                     ctrl_disable
);
    logic              chan_port, ptr_hi;
    logic [SEL_W-1:0]  port_ch;
    logic              port_is_cnt;
    logic              mode_wr;
    logic [NUM_CH-1:0] tc_evt, auto_bits, step_en, mask_w, tc_w;
    logic              dis_w;
    logic [REG_W-1:0]  addr_w [NUM_CH];
    logic [REG_W-1:0]  cnt_w  [NUM_CH];
    chan_mode_t        mode_w [NUM_CH];
    chan_mode_t        mode_in;
    logic [REG_W-1:0]  rd_word;

    assign chan_port   = !io_addr[OFS_W-1];
    assign port_ch     = io_addr[SEL_W:1];
    assign port_is_cnt = io_addr[0];
    assign mode_wr     = io_wr && (io_addr == OFS_MODE);
    assign mode_in     = chan_mode_t'(io_wdata[BYTE_W-1:SEL_W]);
    assign step_en     = step & ~mask_w & {NUM_CH{~dis_w}};

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (io_wr && (io_addr == OFS_PTRCLR || io_addr == OFS_MRST)),
        .toggle ((io_wr || io_rd) && chan_port),
        .hi_sel (ptr_hi)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_we  (io_wr && chan_port && port_ch == SEL_W'(g) && !port_is_cnt),
            .cnt_we   (io_wr && chan_port && port_ch == SEL_W'(g) && port_is_cnt),
            .hi_sel   (ptr_hi),
            .wdata    (io_wdata),
            .mode_we  (mode_wr && io_wdata[SEL_W-1:0] == SEL_W'(g)),
            .mode_in  (mode_in),
            .step_en  (step_en[g]),
            .cur_addr (addr_w[g]),
            .cur_cnt  (cnt_w[g]),
            .mode     (mode_w[g]),
            .tc_evt   (tc_evt[g])
        );
        assign auto_bits[g]                  = mode_w[g].auto_init;
        assign ch_addr[g*REG_W +: REG_W]     = addr_w[g];
        assign ch_count[g*REG_W +: REG_W]    = cnt_w[g];
        assign ch_mode[g*MODE_W +: MODE_W]   = mode_w[g];
    end

    dma_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (io_wr && io_addr == OFS_CMD),
        .smask_we   (io_wr && io_addr == OFS_SMASK),
        .wmask_we   (io_wr && io_addr == OFS_WMASK),
        .unmask_cmd (io_wr && io_addr == OFS_UNMASK),
        .mrst_cmd   (io_wr && io_addr == OFS_MRST),
        .stat_rd    (io_rd && io_addr == OFS_CMD),
        .wbits      (io_wdata[3:0]),
        .tc_evt     (tc_evt),
        .auto_bits  (auto_bits),
        .dis        (dis_w),
        .mask       (mask_w),
        .tc         (tc_w)
    );

    always_comb begin
        rd_word  = port_is_cnt ? cnt_w[port_ch] : addr_w[port_ch];
        io_rdata = '0;
        if (chan_port)
            io_rdata = ptr_hi ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
        else if (io_addr == OFS_CMD)
            io_rdata = {req_in, tc_w};
    end

    assign ch_mask      = mask_w;
    assign ctrl_disable = dis_w;

    // R9
    gated_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_disable && !io_wr) |=> $stable(ch_addr));
endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [3:0]  req_in = '0;
    logic [3:0]  step = '0;
    logic [3:0]  ch_mask;
    logic [23:0] ch_mode;
    logic [63:0] ch_addr;
    logic [63:0] ch_count;
    logic        ctrl_disable;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    dma_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .req_in(req_in),
        .step(step), .ch_mask(ch_mask), .ch_mode(ch_mode), .ch_addr(ch_addr),
        .ch_count(ch_count), .ctrl_disable(ctrl_disable)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse(logic [3:0] s);
        @(negedge clk);
        step = s;
        @(negedge clk);
        step = '0;
    endtask

    // monitor: compares each read against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (io_rd) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL unexpected read: actual %h expected none", io_rdata);
                end else begin
                    chk(tag_q.pop_front(), 64'(io_rdata), 64'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 masks", 64'(ch_mask), 64'hF);
        chk("R1 disable", 64'(ctrl_disable), 64'h0);
        rd(4'd8, 8'h00, "R1 status");
        // R2 R3 low then high, readback
        wr(4'd0, 8'h34); wr(4'd0, 8'h12);
        rd(4'd0, 8'h34, "R3 read lo"); rd(4'd0, 8'h12, "R3 read hi");
        chk("R3 ch0 addr", 64'(ch_addr[15:0]), 64'h1234);
        // R2 pointer rewind
        wr(4'd2, 8'hAA); wr(4'd12, 8'h00); wr(4'd2, 8'h55); wr(4'd2, 8'h66);
        chk("R2 rewind ch1 addr", 64'(ch_addr[31:16]), 64'h6655);
        wr(4'd1, 8'h02); wr(4'd1, 8'h00);
        chk("R3 ch0 count", 64'(ch_count[15:0]), 64'h0002);
        // R7 modes
        wr(4'd11, 8'h50); wr(4'd11, 8'hAA);
        chk("R7 ch0 mode", 64'(ch_mode[5:0]), 64'h14);
        chk("R7 ch2 mode", 64'(ch_mode[17:12]), 64'h2A);
        // R5 single mask
        wr(4'd10, 8'h00); wr(4'd10, 8'h06); wr(4'd10, 8'h01);
        chk("R5 single mask", 64'(ch_mask), 64'hC);
        // R10 auto-init stepping on ch0
        pulse(4'b0001);
        chk("R10 addr inc", 64'(ch_addr[15:0]), 64'h1235);
        chk("R10 cnt dec", 64'(ch_count[15:0]), 64'h0001);
        pulse(4'b0001); pulse(4'b0001);
        chk("R10 auto reload addr", 64'(ch_addr[15:0]), 64'h1234);
        chk("R10 auto reload cnt", 64'(ch_count[15:0]), 64'h0002);
        chk("R10 auto keeps mask", 64'(ch_mask), 64'hC);
        // R9 masked channel ignores step
        pulse(4'b0100);
        chk("R9 masked step addr", 64'(ch_addr[47:32]), 64'h0);
        chk("R9 masked step cnt", 64'(ch_count[47:32]), 64'h0);
        // R8 status and clear on read
        req_in = 4'b1010;
        rd(4'd8, 8'hA1, "R8 status tc0");
        rd(4'd8, 8'hA0, "R8 cleared");
        // R8 same-cycle read and terminal count on ch1 (no auto)
        wr(4'd3, 8'h00); wr(4'd3, 8'h00); wr(4'd11, 8'h45);
        @(negedge clk);
        io_addr = 4'd8; io_rd = 1'b1; step = 4'b0010;
        exp_q.push_back(8'hA0); tag_q.push_back("R8 read during tc");
        @(negedge clk);
        io_rd = 1'b0; step = '0;
        rd(4'd8, 8'hA2, "R8 tc kept");
        rd(4'd8, 8'hA0, "R8 tc cleared");
        chk("R10 no-auto sets mask", 64'(ch_mask), 64'hE);
        chk("R10 wrap cnt", 64'(ch_count[31:16]), 64'hFFFF);
        chk("R10 wrap addr", 64'(ch_addr[31:16]), 64'h6656);
        // R9 disable
        wr(4'd8, 8'h04);
        chk("R9 disable set", 64'(ctrl_disable), 64'h1);
        pulse(4'b0001);
        chk("R9 disabled step", 64'(ch_addr[15:0]), 64'h1234);
        wr(4'd8, 8'h00);
        // R6 write-all and clear-all
        wr(4'd15, 8'h05);
        chk("R6 write all", 64'(ch_mask), 64'h5);
        wr(4'd14, 8'h3C);
        chk("R6 unmask all", 64'(ch_mask), 64'h0);
        // R10 decrement on ch3
        wr(4'd11, 8'h23);
        wr(4'd6, 8'h00); wr(4'd6, 8'h10); wr(4'd7, 8'h05); wr(4'd7, 8'h00);
        pulse(4'b1000);
        chk("R10 addr dec", 64'(ch_addr[63:48]), 64'h0FFF);
        rd(4'd7, 8'h04, "R3 cur cnt lo"); rd(4'd7, 8'h00, "R3 cur cnt hi");
        // R4 master reset
        wr(4'd1, 8'h00); wr(4'd1, 8'h00);
        pulse(4'b0001);
        wr(4'd6, 8'h77); wr(4'd8, 8'h04); wr(4'd13, 8'h00);
        chk("R4 masks", 64'(ch_mask), 64'hF);
        chk("R4 disable", 64'(ctrl_disable), 64'h0);
        wr(4'd6, 8'h88); wr(4'd6, 8'h99);
        chk("R4 ptr low", 64'(ch_addr[63:48]), 64'h9988);
        rd(4'd8, 8'hA0, "R4 status cleared");
        // R11 unmapped reads and request write
        wr(4'd9, 8'hFF);
        rd(4'd9, 8'h00, "R11 read req");
        rd(4'd12, 8'h00, "R11 read cmd port");
        chk("R11 req write masks", 64'(ch_mask), 64'hF);
        rd(4'd8, 8'hA0, "R11 req write status");
        repeat (3) @(negedge clk);
        chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule